// File: doc/BRIEF.md
# Serial Bus Data Strobe Generator

This block derives two strobe outputs from the timing of a time-division-multiplexed serial bus. The bus supplies a data clock that runs at twice the bit rate and a frame sync. Each frame holds twelve 8-bit timeslots, and each strobe is tied to one slot that software selects. In that slot a strobe gives either a steady high pulse or a copy of the bus bit clock, which is the data clock divided by two. Outside its slot a strobe stays low. The first strobe can also gate the output enables of the upstream and downstream data lines. When this gating is on, the lines are driven only during one phase of that strobe, and a polarity bit picks the phase.

The block runs on the data clock. A rising edge of the frame sync, sampled on that clock, starts a frame. The frame then lasts 192 clock cycles, that is 96 bits of two cycles each. If no new sync arrives by then, the strobes fall idle. Software writes three shadow registers: a configuration byte and one 4-bit slot select per strobe. Their values reach the output logic only at the next frame start.

Top module: `serial_strobe_gen`

## Requirements
- R1: After reset the configuration register reads 0x00, both slot select registers read 0x0F, and all strobes are low.
- R2: The configuration register is at address 0x5A. Bit 0 selects clock mode for strobe 1, bit 1 selects clock mode for strobe 2, bit 2 turns on line gating, and bit 3 inverts the gating. Bits 7..4 always read 0. The slot selects for strobes 1 and 2 are at 0x5B and 0x5C, and their bits 7..4 read 0.
- R3: In pulse mode a strobe with slot s is high for exactly frame cycles 16*s to 16*s+15. Cycle 0 is the first cycle after the clock edge that samples the sync rising.
- R4: In clock mode, inside its slot a strobe is high on even frame cycles and low on odd frame cycles.
- R5: A slot select value of 12 to 15 keeps that strobe low for the whole frame.
- R6: With gating off, each data-line enable equals its request input whatever the inversion bit holds.
- R7: With gating on, an enable equals its request ANDed with strobe 1 when inversion is 0, and its request ANDed with the inverse of strobe 1 when inversion is 1.
- R8: Register writes affect outputs only from the next frame start. A write in the same cycle as the start edge first takes effect in the frame after that.
- R9: Strobes are low before the first frame start and from cycle 192 onward when no new sync arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus data clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fsc | input | 1 | Frame sync, a rising edge starts a frame |
| cpu_addr | input | 8 | Register address |
| cpu_wr | input | 1 | Register write strobe |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Register read data for cpu_addr |
| du_req | input | 1 | Upstream line drive request |
| dd_req | input | 1 | Downstream line drive request |
| sds1 | output | 1 | Strobe 1 |
| sds2 | output | 1 | Strobe 2 |
| du_oe | output | 1 | Upstream line output enable |
| dd_oe | output | 1 | Downstream line output enable |

## Verification
A register write and a frame-start edge can fall on the same clock edge. At that edge the active copy loads while the shadow changes. The bench provokes this by raising the write strobe in the same cycle that presents the sync rising. It expects the outgoing frame to follow the old settings and only the frame after that to follow the new ones. A write in the middle of a frame is checked the same way: the rest of that frame must still match the old settings.

// File: rtl/serial_strobe_gen.sv
module serial_strobe_gen #(
  parameter int SLOTS = 12,
  parameter int SLOT_BITS = 8,
  parameter int TS_W = 4,
  parameter logic [7:0] CONF_ADDR = 8'h5A,
  parameter logic [7:0] TS1_ADDR = 8'h5B,
  parameter logic [7:0] TS2_ADDR = 8'h5C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fsc,
  input  logic [7:0] cpu_addr,
  input  logic       cpu_wr,
  input  logic [7:0] cpu_wdata,
  output logic [7:0] cpu_rdata,
  input  logic       du_req,
  input  logic       dd_req,
  output logic       sds1,
  output logic       sds2,
  output logic       du_oe,
  output logic       dd_oe
);
  localparam int SLOT_CYC = 2 * SLOT_BITS;
  localparam int FRAME_CYC = SLOTS * SLOT_CYC;
  localparam int CNT_W = $clog2(FRAME_CYC);
  localparam logic [TS_W-1:0] TS_OFF = '1;

  logic            fsc_q, running, fsc_rise;
  logic [CNT_W-1:0] cnt, slot_idx;
  logic [3:0]      conf_sh, act_conf;
  logic [TS_W-1:0] ts1_sh, ts2_sh, ts1_act, ts2_act;
  logic            in1, in2;

  assign fsc_rise = fsc & ~fsc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fsc_q   <= 1'b0;
      running <= 1'b0;
      cnt     <= '0;
    end else begin
      fsc_q <= fsc;
      if (fsc_rise) begin
        running <= 1'b1;
        cnt     <= '0;
      end else if (running) begin
        if (cnt == CNT_W'(FRAME_CYC - 1)) running <= 1'b0;
        else cnt <= cnt + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conf_sh  <= '0;
      ts1_sh   <= TS_OFF;
      ts2_sh   <= TS_OFF;
      act_conf <= '0;
      ts1_act  <= TS_OFF;
      ts2_act  <= TS_OFF;
    end else begin
      if (cpu_wr) begin
        if (cpu_addr == CONF_ADDR) conf_sh <= cpu_wdata[3:0];
        if (cpu_addr == TS1_ADDR)  ts1_sh  <= cpu_wdata[TS_W-1:0];
        if (cpu_addr == TS2_ADDR)  ts2_sh  <= cpu_wdata[TS_W-1:0];
      end
      if (fsc_rise) begin
        act_conf <= conf_sh;
        ts1_act  <= ts1_sh;
        ts2_act  <= ts2_sh;
      end
    end
  end

  always_comb begin
    cpu_rdata = '0;
    if (cpu_addr == CONF_ADDR)     cpu_rdata[3:0]      = conf_sh;
    else if (cpu_addr == TS1_ADDR) cpu_rdata[TS_W-1:0] = ts1_sh;
    else if (cpu_addr == TS2_ADDR) cpu_rdata[TS_W-1:0] = ts2_sh;
  end

  assign slot_idx = cnt / CNT_W'(SLOT_CYC);
  assign in1 = running && (ts1_act < TS_W'(SLOTS)) && (slot_idx == CNT_W'(ts1_act));
  assign in2 = running && (ts2_act < TS_W'(SLOTS)) && (slot_idx == CNT_W'(ts2_act));

  assign sds1 = in1 & (~act_conf[0] | ~cnt[0]);
  assign sds2 = in2 & (~act_conf[1] | ~cnt[0]);

  assign du_oe = du_req & (~act_conf[2] | (sds1 ^ act_conf[3]));
  assign dd_oe = dd_req & (~act_conf[2] | (sds1 ^ act_conf[3]));
endmodule

module serial_strobe_gen_chk #(
  parameter int TS_W = 4,
  parameter int SLOTS = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            fsc_rise,
  input logic            running,
  input logic [3:0]      act_conf,
  input logic [TS_W-1:0] ts1_act,
  input logic [TS_W-1:0] ts2_act,
  input logic [7:0]      cpu_rdata,
  input logic            du_req,
  input logic            dd_req,
  input logic            sds1,
  input logic            sds2,
  input logic            du_oe,
  input logic            dd_oe
);
  assert_rsvd_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rdata[7:4] == 4'h0);
  assert_clk_mode_toggles_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (act_conf[0] && sds1 && !fsc_rise) |=> !sds1);
  assert_slot_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ts1_act >= TS_W'(SLOTS)) |-> !sds1);
  assert_slot2_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (ts2_act >= TS_W'(SLOTS)) |-> !sds2);
  assert_gate_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !act_conf[2] |-> (du_oe == du_req && dd_oe == dd_req));
  assert_gate_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_conf[2] && (sds1 != act_conf[3])) |-> (du_oe == du_req && dd_oe == dd_req));
  assert_gate_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (act_conf[2] && (sds1 == act_conf[3])) |-> (!du_oe && !dd_oe));
  assert_hold_in_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !fsc_rise |=> ($stable(act_conf) && $stable(ts1_act) && $stable(ts2_act)));
  assert_idle_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> (!sds1 && !sds2));
endmodule

bind serial_strobe_gen serial_strobe_gen_chk #(.TS_W(TS_W), .SLOTS(SLOTS)) chk_i (
  .clk(clk), .rst_n(rst_n), .fsc_rise(fsc_rise), .running(running),
  .act_conf(act_conf), .ts1_act(ts1_act), .ts2_act(ts2_act),
  .cpu_rdata(cpu_rdata), .du_req(du_req), .dd_req(dd_req),
  .sds1(sds1), .sds2(sds2), .du_oe(du_oe), .dd_oe(dd_oe)
);

// File: tb/serial_strobe_gen_tb_top.sv
`timescale 1ns/1ps
module serial_strobe_gen_tb_top;
  logic clk = 0, rst_n = 0, fsc = 0, cpu_wr = 0, du_req = 0, dd_req = 0;
  logic [7:0] cpu_addr = 0, cpu_wdata = 0, cpu_rdata;
  logic sds1, sds2, du_oe, dd_oe;
  int checks = 0, fails = 0;
  logic armed = 0;
  logic [3:0] exp_q[$];
  string tag_q[$];
  logic [3:0] sh_conf = 0, act_conf = 0;
  logic [3:0] sh_ts1 = 4'hF, sh_ts2 = 4'hF, act_ts1 = 4'hF, act_ts2 = 4'hF;

  always #5 clk = ~clk;

  serial_strobe_gen dut_i (
    .clk(clk), .rst_n(rst_n), .fsc(fsc), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .du_req(du_req), .dd_req(dd_req),
    .sds1(sds1), .sds2(sds2), .du_oe(du_oe), .dd_oe(dd_oe));

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (armed && exp_q.size() > 0) begin
      logic [3:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, {4'h0, sds1, sds2, du_oe, dd_oe}, {4'h0, e});
    end
  end

  function automatic void shadow_write(input logic [7:0] a, input logic [7:0] d);
    if (a == 8'h5A) sh_conf = d[3:0];
    if (a == 8'h5B) sh_ts1 = d[3:0];
    if (a == 8'h5C) sh_ts2 = d[3:0];
  endfunction

  task automatic reg_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_wr = 1;
    @(negedge clk);
    cpu_wr = 0;
    shadow_write(a, d);
  endtask

  task automatic reg_read(input string tag, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    cpu_addr = a;
    #1 check(tag, cpu_rdata, exp);
  endtask

  function automatic logic strobe(input int i, input logic [3:0] ts, input logic bcl);
    if (i >= 192 || ts > 4'd11) return 1'b0;
    if (i / 16 != int'(ts)) return 1'b0;
    return bcl ? (i % 2 == 0) : 1'b1;
  endfunction

  task automatic run_frame(input logic du, input logic dd,
                           input bit midw, input logic [7:0] ma, input logic [7:0] md,
                           input bit startw, input logic [7:0] sa, input logic [7:0] sd);
    string base;
    @(negedge clk);
    du_req = du; dd_req = dd;
    act_conf = sh_conf; act_ts1 = sh_ts1; act_ts2 = sh_ts2;
    if (act_ts1 > 4'd11) base = "R5";
    else if (act_conf[0]) base = "R4";
    else base = "R3";
    for (int i = 0; i < 200; i++) begin
      logic s1, s2, g;
      s1 = strobe(i, act_ts1, act_conf[0]);
      s2 = strobe(i, act_ts2, act_conf[1]);
      g = !act_conf[2] || (s1 ^ act_conf[3]);
      exp_q.push_back({s1, s2, du & g, dd & g});
      if (i >= 192) tag_q.push_back("R9");
      else if (startw || midw) tag_q.push_back("R8");
      else if (act_conf[2]) tag_q.push_back("R7");
      else if (act_conf[3]) tag_q.push_back("R6");
      else tag_q.push_back(base);
    end
    fsc = 1;
    if (startw) begin cpu_addr = sa; cpu_wdata = sd; cpu_wr = 1; end
    @(posedge clk);
    armed = 1;
    @(negedge clk);
    fsc = 0;
    if (startw) begin cpu_wr = 0; shadow_write(sa, sd); end
    if (midw) begin
      repeat (50) @(negedge clk);
      cpu_addr = ma; cpu_wdata = md; cpu_wr = 1;
      @(negedge clk);
      cpu_wr = 0;
      shadow_write(ma, md);
    end
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    armed = 0;
  endtask

  initial begin
    #(200000 * 10);
    fails++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {6'h0, sds1, sds2}, 8'h00);
    reg_read("R1", 8'h5A, 8'h00);
    reg_read("R1", 8'h5B, 8'h0F);
    reg_read("R1", 8'h5C, 8'h0F);
    rst_n = 1;
    repeat (2) @(negedge clk);
    // R9 no frame yet
    check("R9", {6'h0, sds1, sds2}, 8'h00);
    // R2 reserved bits and layout
    reg_write(8'h5A, 8'hFF);
    reg_read("R2", 8'h5A, 8'h0F);
    reg_write(8'h5B, 8'hA3);
    reg_read("R2", 8'h5B, 8'h03);
    reg_write(8'h5C, 8'h5B);
    reg_read("R2", 8'h5C, 8'h0B);
    reg_read("R2", 8'h5D, 8'h00);
    // R3 pulse mode, slots 0 and 11
    reg_write(8'h5A, 8'h00); reg_write(8'h5B, 8'h00); reg_write(8'h5C, 8'h0B);
    run_frame(1, 1, 0, 0, 0, 0, 0, 0);
    // R4 clock mode both strobes, same slot
    reg_write(8'h5A, 8'h03); reg_write(8'h5B, 8'h05); reg_write(8'h5C, 8'h05);
    run_frame(1, 0, 0, 0, 0, 0, 0, 0);
    // R5 disabled slots, R6 inversion ignored with gating off
    reg_write(8'h5A, 8'h08); reg_write(8'h5B, 8'h0C); reg_write(8'h5C, 8'h0F);
    run_frame(1, 1, 0, 0, 0, 0, 0, 0);
    reg_write(8'h5B, 8'h04); reg_write(8'h5C, 8'h02);
    run_frame(0, 1, 0, 0, 0, 0, 0, 0);
    // R7 gating, both polarities
    reg_write(8'h5A, 8'h04); reg_write(8'h5B, 8'h03); reg_write(8'h5C, 8'h07);
    run_frame(1, 1, 0, 0, 0, 0, 0, 0);
    reg_write(8'h5A, 8'h0D); reg_write(8'h5B, 8'h02);
    run_frame(1, 1, 0, 0, 0, 0, 0, 0);
    // R8 mid-frame write, then write on start edge
    run_frame(1, 1, 1, 8'h5A, 8'h00, 0, 0, 0);
    run_frame(1, 1, 0, 0, 0, 1, 8'h5A, 8'h04);
    run_frame(1, 0, 0, 0, 0, 0, 0, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule